// File: doc/BRIEF.md
# Power-Up Strap Latch and Frequency Source Selector

This block belongs to a clock synthesizer's control path. Several of the synthesizer's clock output pins also carry configuration straps. The block reads those straps once, when reset is released. The straps are a five-bit frequency code, a shared-pin function strap and a 24/48 MHz select strap. After they are captured, the pins are free to drive clocks, and later pin activity has no effect.

The captured straps are combined with fields from the software control registers. One bit picks whether the hardware code or a six-bit software index selects the frequency table entry. A separate stepless bit overrides both: it passes a direct M/N programme and a divider-ratio code to the synthesizer, where the VCO runs at the reference times (N+4)/M. A tristate-all request is also passed through. The merged setting is registered. Any change to it is flagged with a single-cycle valid pulse, so the PLL sequencer can start a smooth transition.

Top module: `freq_src_sel`

## Requirements
- R1: On the first rising clock edge with `rst_n` high, the strap pins are captured. `pin_pd_mode` then shows the latched mode strap and `sel_24m` the latched 24/48 strap (1 = 24 MHz, 0 = 48 MHz). Later strap pin changes affect no output until the next reset.
- R2: While `rst_n` is low, `pin_pd_mode` = 1 and `sel_24m` = 1, which are the pull defaults. The defaults for the frequency straps are FS[4:0] = 5'b01010. `tbl_index`, `m_out`, `n_out`, `ratio_out`, `stepless_mode`, `tristate_req` and `cfg_valid` are all 0.
- R3: With `stepless_en` = 0 and `sw_sel_en` = 0, `tbl_index` = {1'b0, FS[4:0]}, taken from the captured straps. Hardware selection therefore reaches only entries 0 to 31.
- R4: With `stepless_en` = 0 and `sw_sel_en` = 1, `tbl_index` = `sw_index`, over the full range 0 to 63.
- R5: With `stepless_en` = 1, `stepless_mode` = 1, `m_out` = `m_val`, `n_out` = `n_val` and `ratio_out` = `ratio_code`. `tbl_index` = 0 regardless of `sw_sel_en` and `sw_index`.
- R6: With `stepless_en` = 0, `stepless_mode`, `m_out`, `n_out` and `ratio_out` are all 0, whatever the M, N and ratio inputs hold.
- R7: `cfg_valid` is 1 for exactly the cycles in which any of `tbl_index`, `m_out`, `n_out`, `ratio_out` or `stepless_mode` took a new value at the preceding edge. It is 0 otherwise.
- R8: `tristate_req` follows `sw_tristate` one clock later and does not raise `cfg_valid`.
- R9: All setting outputs appear one clock edge after their inputs. The first edge after reset already reflects the strap pins sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 5 | Frequency-code strap pins |
| strap_mode | input | 1 | Shared-pin function strap (1 = power-down input, 0 = reset output) |
| strap_sel24 | input | 1 | 24/48 MHz strap (1 = 24 MHz) |
| sw_sel_en | input | 1 | Table source: 0 = straps, 1 = software index |
| sw_index | input | 6 | Software table index |
| sw_tristate | input | 1 | Tristate-all request |
| stepless_en | input | 1 | Direct M/N programming enable |
| m_val | input | 5 | M divisor |
| n_val | input | 9 | N multiplier field |
| ratio_code | input | 4 | Divider-ratio code |
| tbl_index | output | 6 | Selected table entry |
| m_out | output | 5 | Registered M |
| n_out | output | 9 | Registered N |
| ratio_out | output | 4 | Registered ratio code |
| stepless_mode | output | 1 | Stepless mode flag |
| tristate_req | output | 1 | Registered tristate request |
| cfg_valid | output | 1 | One-cycle pulse on a setting change |
| pin_pd_mode | output | 1 | Latched shared-pin function select |
| sel_24m | output | 1 | Latched 24/48 MHz select |

## Verification
A capture flag that never sets would let pin activity after start-up leak into `tbl_index` and the pin-function selects. A flag that sets early would leave the pull defaults in place. Either fault shows on the ports within one clock of the strap pins moving. A stale setting register shows as a `cfg_valid` pulse with no visible change, or as a change with no pulse, in the cycle right after the offending edge. Mixing up the stepless and table paths shows as nonzero M/N in table mode or a nonzero index in stepless mode on the same cycle.

// File: rtl/freq_src_sel_pkg.sv
package freq_src_sel_pkg;
  localparam int FS_W  = 5;
  localparam int IDX_W = 6;
  localparam int M_W   = 5;
  localparam int N_W   = 9;
  localparam int RC_W  = 4;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [M_W-1:0]   m;
    logic [N_W-1:0]   n;
    logic [RC_W-1:0]  ratio;
    logic             stepless;
  } synth_cfg_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int          FS_W      = 5,
  parameter logic [FS_W-1:0] FS_DEF = 5'b01010,
  parameter logic        MODE_DEF  = 1'b1,
  parameter logic        SEL_DEF   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_pins,
  input  logic            mode_pin,
  input  logic            sel_pin,
  output logic [FS_W-1:0] fs_eff,
  output logic            mode_q,
  output logic            sel_q,
  output logic            done_q
);
  logic [FS_W-1:0] fs_q;
  logic            latch_en;

  // capture once, on the first edge out of reset
  always_comb begin
    latch_en = !done_q;
    fs_eff   = done_q ? fs_q : fs_pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fs_q   <= FS_DEF;
      mode_q <= MODE_DEF;
      sel_q  <= SEL_DEF;
    end else if (latch_en) begin
      done_q <= 1'b1;
      fs_q   <= fs_pins;
      mode_q <= mode_pin;
      sel_q  <= sel_pin;
    end
  end
endmodule

// File: rtl/cfg_merge.sv
module cfg_merge
  import freq_src_sel_pkg::*;
(
  input  logic [FS_W-1:0]  fs_eff,
  input  logic             sw_sel_en,
  input  logic [IDX_W-1:0] sw_index,
  input  logic             stepless_en,
  input  logic [M_W-1:0]   m_val,
  input  logic [N_W-1:0]   n_val,
  input  logic [RC_W-1:0]  ratio_code,
  output synth_cfg_t       cfg
);
  localparam int PAD_W = IDX_W - FS_W;

  logic [IDX_W-1:0] tbl_sel;

  always_comb begin
    tbl_sel = sw_sel_en ? sw_index : {{PAD_W{1'b0}}, fs_eff};
    if (stepless_en) begin
      cfg.idx      = '0;
      cfg.m        = m_val;
      cfg.n        = n_val;
      cfg.ratio    = ratio_code;
      cfg.stepless = 1'b1;
    end else begin
      cfg.idx      = tbl_sel;
      cfg.m        = '0;
      cfg.n        = '0;
      cfg.ratio    = '0;
      cfg.stepless = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import freq_src_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  synth_cfg_t cfg_new,
  input  logic       tri_in,
  output synth_cfg_t cfg_q,
  output logic       valid_q,
  output logic       tri_q
);
  synth_cfg_t cfg_d;
  logic       valid_d;
  logic       tri_d;

  always_comb begin
    cfg_d   = cfg_new;
    valid_d = (cfg_new != cfg_q);
    tri_d   = tri_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
      tri_q   <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
      tri_q   <= tri_d;
    end
  end
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import freq_src_sel_pkg::*;
#(
  parameter logic [FS_W-1:0] FS_DEF   = 5'b01010,
  parameter logic            MODE_DEF = 1'b1,
  parameter logic            SEL_DEF  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic             strap_mode,
  input  logic             strap_sel24,
  input  logic             sw_sel_en,
  input  logic [IDX_W-1:0] sw_index,
  input  logic             sw_tristate,
  input  logic             stepless_en,
  input  logic [M_W-1:0]   m_val,
  input  logic [N_W-1:0]   n_val,
  input  logic [RC_W-1:0]  ratio_code,
  output logic [IDX_W-1:0] tbl_index,
  output logic [M_W-1:0]   m_out,
  output logic [N_W-1:0]   n_out,
  output logic [RC_W-1:0]  ratio_out,
  output logic             stepless_mode,
  output logic             tristate_req,
  output logic             cfg_valid,
  output logic             pin_pd_mode,
  output logic             sel_24m
);
  logic [FS_W-1:0] fs_eff;
  logic            straps_done;
  synth_cfg_t      cfg_next;
  synth_cfg_t      cfg_cur;

  strap_capture #(
    .FS_W(FS_W), .FS_DEF(FS_DEF), .MODE_DEF(MODE_DEF), .SEL_DEF(SEL_DEF)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .fs_pins(strap_fs), .mode_pin(strap_mode),
    .sel_pin(strap_sel24), .fs_eff(fs_eff), .mode_q(pin_pd_mode),
    .sel_q(sel_24m), .done_q(straps_done)
  );

  cfg_merge u_merge (
    .fs_eff(fs_eff), .sw_sel_en(sw_sel_en), .sw_index(sw_index),
    .stepless_en(stepless_en), .m_val(m_val), .n_val(n_val),
    .ratio_code(ratio_code), .cfg(cfg_next)
  );

  cfg_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cfg_new(cfg_next), .tri_in(sw_tristate),
    .cfg_q(cfg_cur), .valid_q(cfg_valid), .tri_q(tristate_req)
  );

  always_comb begin
    tbl_index     = cfg_cur.idx;
    m_out         = cfg_cur.m;
    n_out         = cfg_cur.n;
    ratio_out     = cfg_cur.ratio;
    stepless_mode = cfg_cur.stepless;
  end
endmodule

// File: rtl/freq_src_sel_chk.sv
module freq_src_sel_chk
  import freq_src_sel_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             straps_done,
  input logic             sw_tristate,
  input logic [IDX_W-1:0] tbl_index,
  input logic [M_W-1:0]   m_out,
  input logic [N_W-1:0]   n_out,
  input logic [RC_W-1:0]  ratio_out,
  input logic             stepless_mode,
  input logic             tristate_req,
  input logic             cfg_valid,
  input logic             pin_pd_mode,
  input logic             sel_24m
);
  assert_pins_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    straps_done |=> ($stable(pin_pd_mode) && $stable(sel_24m)));

  assert_pulse_means_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (!$stable(tbl_index) || !$stable(m_out) || !$stable(n_out) ||
                   !$stable(ratio_out) || !$stable(stepless_mode)));

  assert_quiet_means_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> ($stable(tbl_index) && $stable(m_out) && $stable(n_out) &&
                    $stable(ratio_out) && $stable(stepless_mode)));

  assert_table_mode_zero_mn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stepless_mode |-> (m_out == '0 && n_out == '0 && ratio_out == '0));

  assert_stepless_idx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stepless_mode |-> (tbl_index == '0));

  assert_tristate_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tristate_req == $past(sw_tristate)));
endmodule

bind freq_src_sel freq_src_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .straps_done(straps_done), .sw_tristate(sw_tristate),
  .tbl_index(tbl_index), .m_out(m_out), .n_out(n_out), .ratio_out(ratio_out),
  .stepless_mode(stepless_mode), .tristate_req(tristate_req),
  .cfg_valid(cfg_valid), .pin_pd_mode(pin_pd_mode), .sel_24m(sel_24m)
);

// File: tb/tb_freq_src_sel.sv
module tb_freq_src_sel;
  localparam time CLK_P = 20ns;
  localparam int  NVEC  = 8;

  logic clk, rst_n;
  logic [4:0] strap_fs;
  logic strap_mode, strap_sel24, sw_sel_en, sw_tristate, stepless_en;
  logic [5:0] sw_index;
  logic [4:0] m_val;
  logic [8:0] n_val;
  logic [3:0] ratio_code;
  logic [5:0] tbl_index;
  logic [4:0] m_out;
  logic [8:0] n_out;
  logic [3:0] ratio_out;
  logic stepless_mode, tristate_req, cfg_valid, pin_pd_mode, sel_24m;

  int n_cmp = 0;
  int n_bad = 0;

  freq_src_sel dut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // stimulus: sel, sidx[6], stepless, m[5], n[9], ratio[4], tri
  localparam logic [26:0] STIM [NVEC] = '{
    {1'b0, 6'd45, 1'b0, 5'd3,  9'd100, 4'd5,  1'b0},
    {1'b0, 6'd45, 1'b0, 5'd3,  9'd100, 4'd5,  1'b0},
    {1'b1, 6'd45, 1'b0, 5'd3,  9'd100, 4'd5,  1'b0},
    {1'b1, 6'd63, 1'b0, 5'd3,  9'd100, 4'd5,  1'b1},
    {1'b1, 6'd63, 1'b1, 5'd7,  9'd300, 4'd9,  1'b0},
    {1'b0, 6'd63, 1'b1, 5'd31, 9'd511, 4'd15, 1'b0},
    {1'b1, 6'd5,  1'b1, 5'd31, 9'd511, 4'd15, 1'b1},
    {1'b0, 6'd5,  1'b0, 5'd31, 9'd511, 4'd15, 1'b0}
  };
  // expected: idx[6], m[5], n[9], ratio[4]  (straps latched as 19)
  localparam logic [23:0] EXPV [NVEC] = '{
    {6'd19, 5'd0,  9'd0,   4'd0},
    {6'd19, 5'd0,  9'd0,   4'd0},
    {6'd45, 5'd0,  9'd0,   4'd0},
    {6'd63, 5'd0,  9'd0,   4'd0},
    {6'd0,  5'd7,  9'd300, 4'd9},
    {6'd0,  5'd31, 9'd511, 4'd15},
    {6'd0,  5'd31, 9'd511, 4'd15},
    {6'd19, 5'd0,  9'd0,   4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [26:0] v);
    sw_sel_en   = v[26];
    sw_index    = v[25:20];
    stepless_en = v[19];
    m_val       = v[18:14];
    n_val       = v[13:5];
    ratio_code  = v[4:1];
    sw_tristate = v[0];
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [24:0] prev;
    rst_n = 1'b0;
    strap_fs = 5'd19; strap_mode = 1'b0; strap_sel24 = 1'b0;
    drive({1'b0, 6'd0, 1'b0, 5'd0, 9'd0, 4'd0, 1'b0});
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 pd_mode", pin_pd_mode, 1);
    chk("R2 sel_24m", sel_24m, 1);
    chk("R2 idx", tbl_index, 0);
    chk("R2 valid", cfg_valid, 0);
    chk("R2 tristate", tristate_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R3/R9: first edge reflects captured straps
    chk("R1 pd_mode latched", pin_pd_mode, 0);
    chk("R1 sel_24m latched", sel_24m, 0);
    chk("R3 hw idx", tbl_index, 19);
    chk("R7 first valid", cfg_valid, 1);
    // R1: pin changes after capture are ignored
    strap_fs = 5'd0; strap_mode = 1'b1; strap_sel24 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idx ignores pins", tbl_index, 19);
    chk("R1 pd_mode ignores pins", pin_pd_mode, 0);
    chk("R1 sel_24m ignores pins", sel_24m, 0);
    chk("R7 quiet", cfg_valid, 0);

    // R3..R8 vector walk
    prev = {6'd19, 5'd0, 9'd0, 4'd0, 1'b0};
    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] want;
      drive(STIM[i]);
      want = {EXPV[i], STIM[i][19]};
      @(negedge clk);
      chk($sformatf("R4/R5 idx v%0d", i), tbl_index, EXPV[i][23:18]);
      chk($sformatf("R5/R6 m v%0d", i), m_out, EXPV[i][17:13]);
      chk($sformatf("R5/R6 n v%0d", i), n_out, EXPV[i][12:4]);
      chk($sformatf("R5/R6 ratio v%0d", i), ratio_out, EXPV[i][3:0]);
      chk($sformatf("R5 mode v%0d", i), stepless_mode, STIM[i][19]);
      chk($sformatf("R8 tristate v%0d", i), tristate_req, STIM[i][0]);
      chk($sformatf("R7 valid v%0d", i), cfg_valid, (want != prev));
      prev = want;
    end

    // R8: tristate toggle alone does not pulse valid
    sw_tristate = 1'b1;
    @(negedge clk);
    chk("R8 tristate on", tristate_req, 1);
    chk("R8 no valid", cfg_valid, 0);

    // R2: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R2 async idx", tbl_index, 0);
    chk("R2 async pd_mode", pin_pd_mode, 1);
    chk("R2 async sel", sel_24m, 1);
    // R1/R3: recapture different straps
    drive({1'b0, 6'd0, 1'b0, 5'd0, 9'd0, 4'd0, 1'b0});
    strap_fs = 5'd3; strap_mode = 1'b1; strap_sel24 = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 recapture idx", tbl_index, 3);
    chk("R1 recapture pd_mode", pin_pd_mode, 1);
    chk("R1 recapture sel", sel_24m, 1);
    strap_fs = 5'd31;
    @(negedge clk);
    chk("R1 recapture frozen", tbl_index, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule